// File: doc/BRIEF.md
# Host controller MMIO capability decoder

This block is the memory-mapped front end of a USB 2.0 enhanced host controller. Every memory request that reaches the function passes through it. The block compares the address with a 1 KB window aligned to a programmed base. It then weighs the memory-space enable, the power state and the lock flag, and gives one of three answers: claim the request, forward it to the downstream bus, or master-abort it. The answer comes back one cycle after the request strobe.

Inside the window the block holds the capability register set. A length byte reports where the operational registers begin. A version half-word, a structural-parameters dword and a capability-parameters dword sit next to it. Only the structural-parameters dword can be changed, and only while the write-unlock input is high. Firmware uses that path to tune the controller's advertised structure during start-up. These registers follow only the suspend-well reset. A controller reset or a wake from D3 clears the response path but leaves them intact.

Top module: `hc_mmio_front`

## Requirements
- R1: A request whose address bits above bit 9 differ from the base input is forwarded: the response code is 2.
- R2: When the memory-space enable is low, a request inside the window is forwarded with code 2, even if it is locked or the function is in D3.
- R3: When the memory-space enable is high and the function is in D3, a request inside the window gets master-abort, code 3.
- R4: When the memory-space enable is high, a locked request inside the window gets code 3 and is never forwarded.
- R5: The response is valid on the cycle after the request strobe, and only then. Code 1 means claimed, 2 forwarded, 3 master-abort, and 0 is shown while the response is idle. Read data is zero unless the response is a claimed read.
- R6: The dword at window offset 00h reads 0100_0020h: bits 7:0 carry the length 20h and bits 31:16 carry version 0100h. The output op_offset is constantly 20h.
- R7: After suspend-well reset, offset 04h reads 0010_4208h. Offset 08h always reads 0000_6871h, and every other offset in the window reads zero. Address bits 1:0 do not affect which dword is returned.
- R8: A claimed write to offset 04h while the unlock input is high updates byte i (bits 8i+7:8i) wherever byte-enable bit i is set. Without the unlock, and at any other offset, a write leaves the registers unchanged.
- R9: The capability registers return to their defaults only on the suspend-well reset. A controller reset drops any pending response but keeps the register contents.
- R10: A read issued after a write sees the written value. A read in the same request stream sees the register as it stood when the request was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sus_rst_n | input | 1 | Suspend-well reset, active low, synchronous |
| ctl_rst_n | input | 1 | Controller / D3-to-D0 reset, active low, synchronous |
| base_addr | input | 22 | Window base, address bits 31:10 |
| mem_en | input | 1 | Memory-space enable |
| pwr_d3 | input | 1 | Function is in power state D3 |
| wr_unlock | input | 1 | Allows writes to the structural-parameters dword |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lock | input | 1 | Request is a locked transaction |
| req_addr | input | 32 | Byte address |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_kind | output | 2 | Response code (0 idle, 1 claim, 2 forward, 3 abort) |
| rsp_rdata | output | 32 | Read data for a claimed read, else zero |
| op_offset | output | 8 | Operational register start offset |

## Verification
The bench attacks the order of the routing rules. It drives locked and D3 requests while memory-space enable is low. A decoder that checks lock or power state first would abort them instead of forwarding them. It sends partial byte enables with the unlock high and low. A design that ignores the enables would overwrite bytes it should keep, and one that ignores the unlock would let a write through. A controller reset in the middle of a run is followed by a readback: a register wired to the wrong reset would come back at its default.

// File: rtl/hcm_pkg.sv
package hcm_pkg;
  typedef enum logic [1:0] {
    RSP_IDLE  = 2'd0,
    RSP_CLAIM = 2'd1,
    RSP_FWD   = 2'd2,
    RSP_ABORT = 2'd3
  } rsp_e;

  localparam logic [7:0]  CAP_LEN_VAL  = 8'h20;
  localparam logic [15:0] CAP_VER_VAL  = 16'h0100;
  localparam logic [31:0] STRUCT_RST   = 32'h0010_4208;
  localparam logic [31:0] CAPPAR_VAL   = 32'h0000_6871;
endpackage

// File: rtl/hc_win_route.sv
module hc_win_route
  import hcm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 10
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [ADDR_W-WIN_BITS-1:0] base,
  input  logic                       mem_en,
  input  logic                       pwr_d3,
  input  logic                       lock,
  output logic                       win_hit,
  output rsp_e                       route
);
  function automatic logic hit_f(input logic [ADDR_W-1:0] a,
                                 input logic [ADDR_W-WIN_BITS-1:0] b);
    return a[ADDR_W-1:WIN_BITS] == b;
  endfunction

  function automatic rsp_e route_f(input logic hit, input logic en,
                                   input logic d3, input logic lk);
    if (!hit || !en) return RSP_FWD;
    if (d3 || lk)    return RSP_ABORT;
    return RSP_CLAIM;
  endfunction

  always_comb begin
    win_hit = hit_f(addr, base);
    route   = route_f(win_hit, mem_en, pwr_d3, lock);
  end
endmodule

// File: rtl/hc_cap_file.sv
module hc_cap_file
  import hcm_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             sus_rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] dw_idx,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  output logic [31:0]      rd_data,
  output logic [31:0]      struct_q
);
  localparam logic [IDX_W-1:0] IDX_ID     = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_STRUCT = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_CAPPAR = IDX_W'(2);

  function automatic logic [31:0] merge_f(input logic [31:0] old_v,
                                          input logic [31:0] new_v,
                                          input logic [3:0]  en);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[8*i +: 8] = en[i] ? new_v[8*i +: 8] : old_v[8*i +: 8];
    return r;
  endfunction

  logic struct_wr;
  assign struct_wr = wr_en && (dw_idx == IDX_STRUCT);

  always_ff @(posedge clk) begin
    if (!sus_rst_n)     struct_q <= STRUCT_RST;
    else if (struct_wr) struct_q <= merge_f(struct_q, wdata, be);
  end

  always_comb begin
    case (dw_idx)
      IDX_ID:     rd_data = {CAP_VER_VAL, 8'h00, CAP_LEN_VAL};
      IDX_STRUCT: rd_data = struct_q;
      IDX_CAPPAR: rd_data = CAPPAR_VAL;
      default:    rd_data = 32'h0;
    endcase
  end

  // R8
  hold_unless_wr_chk: assert property (@(posedge clk) disable iff (!sus_rst_n)
    !wr_en |=> $stable(struct_q));
  // R8
  full_write_chk: assert property (@(posedge clk) disable iff (!sus_rst_n)
    (wr_en && dw_idx == IDX_STRUCT && be == 4'hF) |=> struct_q == $past(wdata));
endmodule

// File: rtl/hc_rsp_stage.sv
module hc_rsp_stage
  import hcm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  rsp_e        route,
  input  logic [31:0] rd_data,
  output logic        rsp_valid,
  output rsp_e        rsp_kind,
  output logic [31:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= RSP_IDLE;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= req_valid;
      rsp_kind  <= req_valid ? route : RSP_IDLE;
      rsp_rdata <= (req_valid && !req_write && route == RSP_CLAIM) ? rd_data : 32'h0;
    end
  end

  // R5
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R5
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_kind == RSP_IDLE));
  // R5
  data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_kind != RSP_CLAIM) |-> rsp_rdata == 32'h0);
endmodule

// File: rtl/hc_mmio_front.sv
module hc_mmio_front
  import hcm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 10
) (
  input  logic                       clk,
  input  logic                       sus_rst_n,
  input  logic                       ctl_rst_n,
  input  logic [ADDR_W-WIN_BITS-1:0] base_addr,
  input  logic                       mem_en,
  input  logic                       pwr_d3,
  input  logic                       wr_unlock,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic                       req_lock,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [3:0]                 req_be,
  input  logic [31:0]                req_wdata,
  output logic                       rsp_valid,
  output logic [1:0]                 rsp_kind,
  output logic [31:0]                rsp_rdata,
  output logic [7:0]                 op_offset
);
  localparam int IDX_W = WIN_BITS - 2;

  logic             win_hit;
  rsp_e             route;
  rsp_e             kind_q;
  logic             rst_n;
  logic             cap_wr;
  logic [IDX_W-1:0] dw_idx;
  logic [31:0]      rd_data;
  logic [31:0]      struct_q;

  assign rst_n     = sus_rst_n && ctl_rst_n;
  assign dw_idx    = req_addr[WIN_BITS-1:2];
  assign cap_wr    = req_valid && req_write && wr_unlock && (route == RSP_CLAIM);
  assign op_offset = CAP_LEN_VAL;
  assign rsp_kind  = kind_q;

  hc_win_route #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_route (
    .addr(req_addr), .base(base_addr), .mem_en(mem_en), .pwr_d3(pwr_d3),
    .lock(req_lock), .win_hit(win_hit), .route(route)
  );

  hc_cap_file #(.IDX_W(IDX_W)) u_cap (
    .clk(clk), .sus_rst_n(sus_rst_n), .wr_en(cap_wr), .dw_idx(dw_idx),
    .be(req_be), .wdata(req_wdata), .rd_data(rd_data), .struct_q(struct_q)
  );

  hc_rsp_stage u_rsp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .route(route), .rd_data(rd_data), .rsp_valid(rsp_valid),
    .rsp_kind(kind_q), .rsp_rdata(rsp_rdata)
  );

  // R1
  outside_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !win_hit) |=> kind_q == RSP_FWD);
  // R2
  mem_off_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mem_en) |=> kind_q == RSP_FWD);
  // R3
  d3_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_hit && mem_en && pwr_d3) |=> kind_q == RSP_ABORT);
  // R4
  lock_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_hit && mem_en && req_lock) |=> kind_q == RSP_ABORT);
  // R9
  keep_on_ctl_rst_chk: assert property (@(posedge clk) disable iff (!sus_rst_n)
    !ctl_rst_n |=> $stable(struct_q));
endmodule

// File: tb/test_hc_mmio_front.sv
module test_hc_mmio_front;
  localparam int CLK_PERIOD = 10;
  localparam logic [21:0] BASE = 22'h12345;

  logic        clk = 1'b0;
  logic        sus_rst_n = 1'b0, ctl_rst_n = 1'b1;
  logic [21:0] base_addr = BASE;
  logic        mem_en = 1'b1, pwr_d3 = 1'b0, wr_unlock = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_lock = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_kind;
  logic [31:0] rsp_rdata;
  logic [7:0]  op_offset;

  int checks = 0, fails = 0;
  logic [31:0] m_struct = 32'h0010_4208;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hc_mmio_front i_hc_mmio_front (
    .clk(clk), .sus_rst_n(sus_rst_n), .ctl_rst_n(ctl_rst_n), .base_addr(base_addr),
    .mem_en(mem_en), .pwr_d3(pwr_d3), .wr_unlock(wr_unlock), .req_valid(req_valid),
    .req_write(req_write), .req_lock(req_lock), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_rdata(rsp_rdata), .op_offset(op_offset)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_kind(input logic [31:0] a, input logic lk);
    if (a[31:10] != BASE) return 2'd2;       // R1
    if (!mem_en) return 2'd2;                 // R2
    if (pwr_d3) return 2'd3;                  // R3
    if (lk) return 2'd3;                      // R4
    return 2'd1;
  endfunction

  function automatic logic [31:0] exp_dword(input logic [31:0] a);
    case (a[9:2])
      8'd0: return 32'h0100_0020;             // R6
      8'd1: return m_struct;                  // R7
      8'd2: return 32'h0000_6871;             // R7
      default: return 32'h0;
    endcase
  endfunction

  task automatic access(input string req, input logic wr, input logic lk,
                        input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
    logic [1:0]  ek;
    logic [31:0] ed;
    ek = exp_kind(a, lk);
    ed = (ek == 2'd1 && !wr) ? exp_dword(a) : 32'h0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_lock = lk; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    check({req, " R5 valid"}, {31'b0, rsp_valid}, 32'd1);
    check({req, " kind"}, {30'b0, rsp_kind}, {30'b0, ek});
    check({req, " data"}, rsp_rdata, ed);
    if (ek == 2'd1 && wr && wr_unlock && a[9:2] == 8'd1)
      for (int i = 0; i < 4; i++) if (be[i]) m_struct[8*i +: 8] = d[8*i +: 8];
  endtask

  function automatic logic [31:0] in_win(input logic [9:0] off);
    return {BASE, off};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    sus_rst_n = 1;
    @(negedge clk);
    check("R5 reset idle valid", {31'b0, rsp_valid}, 32'd0);
    check("R5 reset idle kind", {30'b0, rsp_kind}, 32'd0);
    check("R6 op_offset", {24'b0, op_offset}, 32'h20);
    access("R6 id dword", 0, 0, in_win(10'h000), 4'hF, 0);
    access("R7 struct default", 0, 0, in_win(10'h004), 4'hF, 0);
    access("R7 cap params", 0, 0, in_win(10'h008), 4'hF, 0);
    access("R7 unimpl 0Ch", 0, 0, in_win(10'h00C), 4'hF, 0);
    access("R7 low bits ignored", 0, 0, in_win(10'h002), 4'h4, 0);
    access("R8 locked-out write", 1, 0, in_win(10'h004), 4'hF, 32'hDEAD_BEEF);
    access("R8 readback unchanged", 0, 0, in_win(10'h004), 4'hF, 0);
    wr_unlock = 1;
    access("R8 partial write", 1, 0, in_win(10'h004), 4'b0101, 32'hAABB_CCDD);
    access("R10 readback merged", 0, 0, in_win(10'h004), 4'hF, 0);
    check("R8 model merge", m_struct, 32'h00BB_42DD);
    access("R8 write other offset", 1, 0, in_win(10'h008), 4'hF, 32'h1234_5678);
    access("R8 other offset unchanged", 0, 0, in_win(10'h008), 4'hF, 0);
    access("R4 locked read", 0, 1, in_win(10'h004), 4'hF, 0);
    access("R4 locked write", 1, 1, in_win(10'h004), 4'hF, 32'h0);
    access("R10 after locked write", 0, 0, in_win(10'h004), 4'hF, 0);
    pwr_d3 = 1;
    access("R3 d3 read", 0, 0, in_win(10'h000), 4'hF, 0);
    mem_en = 0;
    access("R2 off with d3 lock", 0, 1, in_win(10'h000), 4'hF, 0);
    pwr_d3 = 0;
    access("R2 off read", 0, 0, in_win(10'h004), 4'hF, 0);
    mem_en = 1;
    access("R1 outside", 0, 0, 32'h0000_0004, 4'hF, 0);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_lock = 0; req_addr = in_win(10'h004);
    ctl_rst_n = 0;
    @(negedge clk);
    req_valid = 0; ctl_rst_n = 1;
    check("R9 ctl reset drops response", {31'b0, rsp_valid}, 32'd0);
    access("R9 kept across ctl reset", 0, 0, in_win(10'h004), 4'hF, 0);
    @(negedge clk);
    sus_rst_n = 0;
    @(negedge clk);
    sus_rst_n = 1;
    m_struct = 32'h0010_4208;
    access("R9 suspend reset default", 0, 0, in_win(10'h004), 4'hF, 0);

    void'($urandom(32'd20240611));
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic [31:0] r;
      r = $urandom;
      mem_en    = (r[3:0] != 0);
      pwr_d3    = (r[7:4] == 0);
      wr_unlock = r[8];
      a = r[9] ? in_win({4'b0, 6'($urandom)}) : $urandom;
      if (r[10] && r[9]) a = in_win(10'h004 | 10'($urandom % 4));
      access("R1-route R5 random", r[11], (r[15:12] == 0), a, 4'($urandom), $urandom);
    end
    mem_en = 1; pwr_d3 = 0;
    access("R10 final readback", 0, 0, in_win(10'h004), 4'hF, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule